// File: doc/BRIEF.md
# Daisy-Chain Device Address Selector

This block gives one device in a daisy chain its own page address, and it decides whether that device is the current target of the shared bus. It holds two 16-bit registers. The page address register names the device. The device select register names the device that the host wants to reach. The host loads either register in two steps. First it issues a command that names the register as target. Then it issues a command-write cycle that carries the value.

The device counts as selected when the two registers hold the same value. A select value of all ones is a broadcast: it selects every device in the chain, but reads are then not allowed, because several devices would drive the bus at once. A software reset leaves both registers as they are. A disabled full-flag enable locks the page address register against writes. A hardware reset clears both registers to zero, so after power-up every device matches until it is given an address.

Top module: `chain_addr_select`

## Requirements
- R1: A command cycle (`cmd_valid`=1) with `cmd_op`=2'b01 arms a page-address load. On the next command-write cycle (`cw_valid`=1, `cmd_valid`=0, `soft_reset`=0), `page_addr` takes `cw_data` at that clock edge.
- R2: A page-address load whose value is 16'hFFFF is rejected, and `page_addr` keeps its old value.
- R3: A command cycle with `cmd_op`=2'b10 arms a device-select load. The next command-write cycle stores `cw_data` in the device select register, which reads back on `dev_sel`. Any 16-bit value is accepted, including 16'hFFFF.
- R4: When `dev_sel` differs from 16'hFFFF, `selected` is 1 exactly when `dev_sel` equals `page_addr`, and `read_ok` equals `selected`.
- R5: When `dev_sel` is 16'hFFFF, `selected` is 1 and `read_ok` is 0, whatever `page_addr` holds.
- R6: A cycle with `soft_reset`=1 changes neither register. It cancels any armed load, and a command-write in that same cycle stores nothing.
- R7: While `ff_enable`=0, page-address loads are ignored. Device-select loads still work.
- R8: A clock edge with `rst_n`=0 clears both registers to 16'h0000, which gives `selected`=1 and `read_ok`=1.
- R9: An armed load is used up by the first command-write cycle that follows it. A command-write with nothing armed stores nothing. A command with `cmd_op` 2'b00 or 2'b11 cancels a pending load.
- R10: When `cmd_valid` and `cw_valid` are both 1 in the same cycle, the command is taken and the write data is discarded.
- R11: `selected` and `read_ok` reflect a completed load right after the clock edge that stores it, with no extra cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| cmd_valid | input | 1 | Command cycle strobe |
| cmd_op | input | 2 | Command code: 01 target page address, 10 target device select, others unrelated |
| cw_valid | input | 1 | Command-write cycle strobe |
| cw_data | input | 16 | Value carried by the command-write cycle |
| soft_reset | input | 1 | Software reset pulse from the control register |
| ff_enable | input | 1 | Full-flag enable; 0 locks the page address register |
| page_addr | output | 16 | Current page address |
| dev_sel | output | 16 | Current device select value (read-back) |
| selected | output | 1 | Device is the current target |
| read_ok | output | 1 | Reads from this device are permitted |

## Verification
The match logic is exercised in three situations: select values equal to the page address, select values that differ from it, and the all-ones broadcast. These separate a true match from a broadcast, and a broadcast from a read-permitted selection. Random command streams mix arming commands, unrelated commands, command-writes with and without an armed target, and collisions between commands and writes. Those streams test the one-shot arming separately from the data path. Write values of 16'hFFFF, cycles with the full flag disabled, and soft-reset pulses are injected so that each guard on the page address shows up on its own. Hardware reset is applied again in the middle of the run, to check the power-up state as well as the guards.

// File: rtl/chain_sel_pkg.sv
// Shared types for the daisy-chain address selector.
// Assumes a 2-bit command code.
package chain_sel_pkg;
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_PAGE = 2'd1,
        TGT_SEL  = 2'd2
    } target_e;

    localparam logic [1:0] OP_TGT_PAGE = 2'b01;
    localparam logic [1:0] OP_TGT_SEL  = 2'b10;
endpackage

// File: rtl/cs_target_tracker.sv
// Remembers which register the last command named as load target.
// The target stays armed only until the next command-write cycle.
// A soft reset or an unrelated command cancels it.
// Assumes a command cycle takes precedence over a write in the same cycle.
module cs_target_tracker
    import chain_sel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       cw_valid,
    input  logic       soft_reset,
    output logic       load_page,
    output logic       load_sel
);
    target_e armed_q;
    logic    write_cycle;

    // A write only counts when no command and no soft reset compete with it.
    always_comb begin
        write_cycle = cw_valid && !cmd_valid && !soft_reset;
        load_page   = write_cycle && (armed_q == TGT_PAGE);
        load_sel    = write_cycle && (armed_q == TGT_SEL);
    end

    // Arm on a target command; disarm on soft reset, another command or a consumed write.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_reset) begin
            armed_q <= TGT_NONE;
        end else if (cmd_valid) begin
            unique case (cmd_op)
                OP_TGT_PAGE: armed_q <= TGT_PAGE;
                OP_TGT_SEL:  armed_q <= TGT_SEL;
                default:     armed_q <= TGT_NONE;
            endcase
        end else if (cw_valid) begin
            armed_q <= TGT_NONE;
        end
    end
endmodule

// File: rtl/cs_addr_reg.sv
// One address register with optional write guards.
// With GUARD_ONES set, an all-ones value is refused.
// The wr_allow input can lock the register.
// Hardware reset clears it; nothing else does.
module cs_addr_reg #(
    parameter int W          = 16,
    parameter bit GUARD_ONES = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         wr_allow,
    input  logic [W-1:0] data,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic accept;

    // Decide whether this load passes the guards chosen at build time.
    generate
        if (GUARD_ONES) begin : g_guard
            always_comb accept = load && wr_allow && (data != ALL_ONES);
        end else begin : g_open
            always_comb accept = load && wr_allow;
        end
    endgenerate

    // Hold the value; update only on an accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (accept) q <= data;
    end
endmodule

// File: rtl/cs_match.sv
// Select and read-permission decode from the two register values.
// An all-ones select value is a broadcast that blocks reads.
module cs_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] page_addr,
    input  logic [W-1:0] dev_sel,
    output logic         selected,
    output logic         read_ok
);
    localparam logic [W-1:0] BCAST = {W{1'b1}};

    logic is_bcast;
    logic is_match;

    // Combine exact match and broadcast into the two flags.
    always_comb begin
        is_bcast = (dev_sel == BCAST);
        is_match = (dev_sel == page_addr);
        selected = is_match || is_bcast;
        read_ok  = is_match && !is_bcast;
    end
endmodule

// File: rtl/chain_addr_select.sv
// Top of the daisy-chain address selector.
// Ties the target tracker, the two address registers and the match decode together.
// Assumes the synchronous active-low rst_n is the hardware reset.
// soft_reset only cancels a pending load.
module chain_addr_select #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [1:0]   cmd_op,
    input  logic         cw_valid,
    input  logic [W-1:0] cw_data,
    input  logic         soft_reset,
    input  logic         ff_enable,
    output logic [W-1:0] page_addr,
    output logic [W-1:0] dev_sel,
    output logic         selected,
    output logic         read_ok
);
    logic load_page;
    logic load_sel;

    cs_target_tracker u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cw_valid   (cw_valid),
        .soft_reset (soft_reset),
        .load_page  (load_page),
        .load_sel   (load_sel)
    );

    cs_addr_reg #(.W(W), .GUARD_ONES(1'b1)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_page),
        .wr_allow (ff_enable),
        .data     (cw_data),
        .q        (page_addr)
    );

    cs_addr_reg #(.W(W), .GUARD_ONES(1'b0)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_sel),
        .wr_allow (1'b1),
        .data     (cw_data),
        .q        (dev_sel)
    );

    cs_match #(.W(W)) u_match (
        .page_addr (page_addr),
        .dev_sel   (dev_sel),
        .selected  (selected),
        .read_ok   (read_ok)
    );
endmodule

// File: rtl/chain_addr_select_chk.sv
// Property checker for chain_addr_select, attached by bind below.
module chain_addr_select_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_valid,
    input logic         cw_valid,
    input logic [W-1:0] cw_data,
    input logic         soft_reset,
    input logic         ff_enable,
    input logic [W-1:0] page_addr,
    input logic [W-1:0] dev_sel,
    input logic         selected,
    input logic         read_ok,
    input logic         load_page,
    input logic         load_sel
);
    localparam logic [W-1:0] ONES = {W{1'b1}};

    // R1
    pa_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_page && ff_enable && cw_data != ONES) |=> page_addr == $past(cw_data));

    // R2
    pa_reject_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && cw_data == ONES) |=> $stable(page_addr));

    // R3
    ds_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_sel |=> dev_sel == $past(cw_data));

    // R5
    bcast_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_sel == ONES) |-> (selected && !read_ok));

    // R4
    read_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        read_ok |-> selected);

    // R6
    soft_reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |=> ($stable(page_addr) && $stable(dev_sel)));

    // R7
    ff_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ff_enable |=> $stable(page_addr));

    // R10
    cmd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cw_valid) |=> ($stable(page_addr) && $stable(dev_sel)));

    // R8
    hw_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (page_addr == '0 && dev_sel == '0));
endmodule

bind chain_addr_select chain_addr_select_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cw_valid   (cw_valid),
    .cw_data    (cw_data),
    .soft_reset (soft_reset),
    .ff_enable  (ff_enable),
    .page_addr  (page_addr),
    .dev_sel    (dev_sel),
    .selected   (selected),
    .read_ok    (read_ok),
    .load_page  (load_page),
    .load_sel   (load_sel)
);

// File: tb/chain_addr_select_test.sv
module chain_addr_select_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic        cw_valid = 1'b0;
    logic [15:0] cw_data = 16'h0;
    logic        soft_reset = 1'b0;
    logic        ff_enable = 1'b1;
    logic [15:0] page_addr, dev_sel;
    logic        selected, read_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [15:0] m_pa = 16'h0;
    logic [15:0] m_ds = 16'h0;
    int          m_arm = 0;     // 0 none, 1 page, 2 select

    always #10 clk = ~clk;      // 50 MHz

    chain_addr_select uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cw_valid(cw_valid), .cw_data(cw_data), .soft_reset(soft_reset),
        .ff_enable(ff_enable), .page_addr(page_addr), .dev_sel(dev_sel),
        .selected(selected), .read_ok(read_ok)
    );

    function automatic logic exp_sel(input logic [15:0] pa, input logic [15:0] ds);
        return (ds == pa) || (ds == 16'hFFFF);
    endfunction

    function automatic logic exp_rd(input logic [15:0] pa, input logic [15:0] ds);
        return (ds == pa) && (ds != 16'hFFFF);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, advance the model, then compare after the edge.
    task automatic step(input logic cv, input logic [1:0] op, input logic wv,
                        input logic [15:0] d, input logic ff, input logic sr,
                        input logic rn, input string tag);
        logic wr;
        @(negedge clk);
        cmd_valid = cv; cmd_op = op; cw_valid = wv; cw_data = d;
        ff_enable = ff; soft_reset = sr; rst_n = rn;
        wr = wv && !cv && !sr;
        if (!rn) begin
            m_pa = 16'h0; m_ds = 16'h0; m_arm = 0;
        end else begin
            if (wr && m_arm == 1 && ff && d != 16'hFFFF) m_pa = d;
            if (wr && m_arm == 2) m_ds = d;
            if (sr) m_arm = 0;
            else if (cv) m_arm = (op == 2'b01) ? 1 : (op == 2'b10) ? 2 : 0;
            else if (wv) m_arm = 0;
        end
        @(posedge clk);
        #1;
        chk({tag, " page_addr"}, page_addr, m_pa);
        chk({tag, " dev_sel"}, dev_sel, m_ds);
        chk({tag, " selected"}, {15'd0, selected}, {15'd0, exp_sel(m_pa, m_ds)});
        chk({tag, " read_ok"}, {15'd0, read_ok}, {15'd0, exp_rd(m_pa, m_ds)});
    endtask

    task automatic load(input logic [1:0] op, input logic [15:0] d, input logic ff, input string tag);
        step(1'b1, op, 1'b0, 16'h0, ff, 1'b0, 1'b1, tag);
        step(1'b0, 2'b00, 1'b1, d, ff, 1'b0, 1'b1, tag);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        step(1'b0, 2'b00, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0, "R8 reset");
        step(1'b0, 2'b00, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0, "R8 reset");
        // R8: registers zero, so the device matches with reads allowed
        chk("R8 selected after reset", {15'd0, selected}, 16'd1);
        chk("R8 read_ok after reset", {15'd0, read_ok}, 16'd1);
        load(2'b01, 16'h0012, 1'b1, "R1 page load");
        chk("R1 page value", page_addr, 16'h0012);
        load(2'b10, 16'h0012, 1'b1, "R3 R11 select load");
        chk("R4 R11 selected on load edge", {15'd0, selected}, 16'd1);
        load(2'b01, 16'hFFFF, 1'b1, "R2 page all ones");
        chk("R2 page kept", page_addr, 16'h0012);
        load(2'b01, 16'h0034, 1'b0, "R7 locked page");
        chk("R7 page kept", page_addr, 16'h0012);
        load(2'b10, 16'h0034, 1'b0, "R7 select still loads");
        chk("R4 mismatch not selected", {15'd0, selected}, 16'd0);
        load(2'b10, 16'hFFFF, 1'b1, "R5 broadcast");
        chk("R5 broadcast read blocked", {15'd0, read_ok}, 16'd0);
        // R9: an unrelated command cancels, and a bare write stores nothing
        step(1'b1, 2'b01, 1'b0, 16'h0, 1'b1, 1'b0, 1'b1, "R9 arm");
        step(1'b1, 2'b11, 1'b0, 16'h0, 1'b1, 1'b0, 1'b1, "R9 cancel");
        step(1'b0, 2'b00, 1'b1, 16'h0055, 1'b1, 1'b0, 1'b1, "R9 write after cancel");
        step(1'b0, 2'b00, 1'b1, 16'h0066, 1'b1, 1'b0, 1'b1, "R9 write unarmed");
        chk("R9 page kept", page_addr, 16'h0012);
        // R6: a soft reset keeps the registers and cancels the armed load
        step(1'b1, 2'b10, 1'b0, 16'h0, 1'b1, 1'b0, 1'b1, "R6 arm");
        step(1'b0, 2'b00, 1'b1, 16'h0077, 1'b1, 1'b1, 1'b1, "R6 soft reset with write");
        step(1'b0, 2'b00, 1'b1, 16'h0088, 1'b1, 1'b0, 1'b1, "R6 write after soft reset");
        chk("R6 select kept", dev_sel, 16'hFFFF);
        // R10: command and write together, so the command wins
        step(1'b1, 2'b01, 1'b0, 16'h0, 1'b1, 1'b0, 1'b1, "R10 arm");
        step(1'b1, 2'b10, 1'b1, 16'h0099, 1'b1, 1'b0, 1'b1, "R10 collide");
        chk("R10 page kept", page_addr, 16'h0012);
        step(1'b0, 2'b00, 1'b1, 16'h00AA, 1'b1, 1'b0, 1'b1, "R10 re-armed select");
        chk("R10 select took new target", dev_sel, 16'h00AA);
        // random mix, checked against the model
        for (int i = 0; i < 3000; i++) begin
            logic [1:0]  op;
            logic [15:0] d;
            int          r;
            op = 2'($urandom_range(0, 3));
            r  = $urandom_range(0, 7);
            d  = (r == 0) ? 16'hFFFF : (r < 3) ? m_pa : (r < 5) ? m_ds : 16'($urandom_range(0, 15));
            step($urandom_range(0, 2) == 0, op, $urandom_range(0, 1) == 1, d,
                 $urandom_range(0, 5) != 0, $urandom_range(0, 15) == 0,
                 (i == 1500) ? 1'b0 : 1'b1,
                 (i == 1500) ? "R8 mid reset" : "R4 R5 random");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule